// File: doc/BRIEF.md
# Half-Bridge Overcurrent Limiter with Overload Shutdown

This block guards the half-bridges of a class-D power stage against overcurrent. Each half-bridge has its own limiter. The limiter takes the comparator flag that says the bridge current is above its threshold, and the strobe that marks the start of every PWM frame. With the soft mode selected, an overcurrent event inverts the bridge's drive bit for the rest of the frame. A leaky up/down overload counter also runs. It gains one step for every frame that holds an event and loses one for every frame that holds none. When the counter reaches its limit, the channel is shut down and stays shut down. With the hard mode selected, the first event shuts the channel down at once.

A shut-down channel sets its fault flag. Its drive goes to high impedance, and its drive bit is forced low. In bridge-tied operation the half-bridges are grouped in pairs, (0,1) and (2,3). A fault on either member of a pair floats both members. In single-ended operation each half-bridge floats alone. Only the active-low reset clears a shutdown, and the same reset clears the overload counter.

The counter limit comes from two parameters, the PWM frame rate and a trip window of about 2.6 ms. The defaults, 400 kHz and 2600 us, give a limit of 1040 frames.

Top module: `hb_oc_guard`

## Requirements
- R1: After reset, all bits of `hiz_out` and `fault_out` are 0, and `drive_out` equals `pwm_in`.
- R2: In soft mode (`latch_mode`=0), an overcurrent sample on a live half-bridge inverts that bit of `drive_out` from the next cycle onward. The inversion ends with the cycle after the next `frame_start` cycle, unless an overcurrent sample arrives in that `frame_start` cycle.
- R3: The overload counter counts at most one event per frame. It rises by 1 in each frame that holds an event, falls by 1 at each frame start that closes a frame without one, and saturates at 0.
- R4: In soft mode, the cycle after the counter reaches its limit, that half-bridge's `fault_out` bit goes to 1. The limit is frame rate x trip window, which is 1040 frames with the default parameters.
- R5: In hard mode (`latch_mode`=1), the first overcurrent sample sets that half-bridge's `fault_out` bit in the next cycle.
- R6: Once a `fault_out` bit is set, it stays set, whatever `oc_in` and `frame_start` do, until `rst_n` is driven low.
- R7: With `se_mode`=0, a fault on half-bridge 0 or 1 sets `hiz_out[1:0]` to 2'b11, and a fault on half-bridge 2 or 3 sets `hiz_out[3:2]` to 2'b11. The other pair is not affected.
- R8: With `se_mode`=1, a fault sets only that half-bridge's own `hiz_out` bit.
- R9: Suppose a frame holds no event and an overcurrent sample arrives in the following `frame_start` cycle. The decrement and the increment then cancel, and the count is left as it was.
- R10: Frames without events that pass while the counter is at 0 do not push the trip point later.
- R11: A half-bridge whose `hiz_out` bit is 1 drives 0 on its `drive_out` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Clears the counters, the flips and the shutdown latches |
| frame_start | input | 1 | High for one cycle at the start of each PWM frame |
| pwm_in | input | N_HB | Drive bit for each half-bridge |
| oc_in | input | N_HB | Overcurrent comparator flag for each half-bridge |
| latch_mode | input | 1 | 0 = cycle-by-cycle limiting, 1 = shutdown on the first event |
| se_mode | input | 1 | 0 = bridge-tied pairs, 1 = independent single-ended bridges |
| drive_out | output | N_HB | Drive bits after flipping and shutdown |
| hiz_out | output | N_HB | High-impedance request for each half-bridge |
| fault_out | output | N_HB | Latched channel fault for each half-bridge |

## Verification
In the cycle that carries `frame_start`, the counter may have to take its decrement for the frame just ended and its increment for a new event at the same time. The bench provokes this case. It first pumps a bridge to one step below the limit. It then leaves one frame empty, and raises the overcurrent flag in the next strobe cycle. The bench judges the outcome by the trip point. The channel must stay healthy at that moment, and it must trip on the very next event. A design that drops either update trips too early or too late.

// File: rtl/hb_oc_pkg.sv
package hb_oc_pkg;

  // Number of frames that fit in the trip window.
  function automatic int unsigned frames_in_window(int unsigned rate_hz, int unsigned window_us);
    return (rate_hz / 1000) * window_us / 1000;
  endfunction

  // One step of the leaky counter, saturating at 0 and at top.
  function automatic int unsigned cnt_step(int unsigned cur, logic up, logic down,
                                           int unsigned top);
    if (up && !down) return (cur >= top) ? top : cur + 1;
    if (down && !up) return (cur == 0) ? 0 : cur - 1;
    return cur;
  endfunction

endpackage

// File: rtl/hb_limiter.sv
module hb_limiter
  import hb_oc_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int CNT_MAX = 1040
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic pwm,
  input  logic oc,
  input  logic latch_mode,
  output logic drive_mod,
  output logic latched,
  output logic trip_evt
);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(CNT_MAX);

  logic             flip_q, seen_q, latched_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             oc_evt, first_evt, cnt_up, cnt_dn, soft_evt, flip_nxt;

  // An event counts only while the channel is still live.
  assign oc_evt    = oc & ~latched_q;
  assign first_evt = oc_evt & (frame_start | ~seen_q);
  assign soft_evt  = oc_evt & ~latch_mode;
  assign cnt_up    = first_evt & ~latch_mode;
  assign cnt_dn    = frame_start & ~seen_q;

  assign cnt_nxt  = CNT_W'(cnt_step({{(32-CNT_W){1'b0}}, cnt_q}, cnt_up, cnt_dn, CNT_MAX));
  assign trip_evt = (latch_mode & oc_evt) | (cnt_up & (cnt_nxt == MAX_V));
  assign flip_nxt = frame_start ? soft_evt : (flip_q | soft_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flip_q    <= 1'b0;
      seen_q    <= 1'b0;
      latched_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      flip_q <= flip_nxt;
      seen_q <= frame_start ? oc_evt : (seen_q | oc_evt);
      cnt_q  <= cnt_nxt;
      if (trip_evt) latched_q <= 1'b1;
    end
  end

  assign drive_mod = pwm ^ flip_q;
  assign latched   = latched_q;

endmodule

// File: rtl/hb_pairing.sv
module hb_pairing #(
  parameter int N_HB = 4
) (
  input  logic [N_HB-1:0] latched,
  input  logic            se_mode,
  output logic [N_HB-1:0] hiz
);
  localparam int N_PAIR = N_HB / 2;

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    logic pair_off;
    assign pair_off     = latched[2*p] | latched[2*p+1];
    assign hiz[2*p]     = se_mode ? latched[2*p]   : pair_off;
    assign hiz[2*p+1]   = se_mode ? latched[2*p+1] : pair_off;
  end

endmodule

// File: rtl/hb_oc_guard.sv
module hb_oc_guard
  import hb_oc_pkg::*;
#(
  parameter int N_HB           = 4,
  parameter int CNT_W          = 12,
  parameter int FRAME_RATE_HZ  = 400000,
  parameter int TRIP_WINDOW_US = 2600
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic [N_HB-1:0] pwm_in,
  input  logic [N_HB-1:0] oc_in,
  input  logic            latch_mode,
  input  logic            se_mode,
  output logic [N_HB-1:0] drive_out,
  output logic [N_HB-1:0] hiz_out,
  output logic [N_HB-1:0] fault_out
);
  localparam int CNT_MAX = int'(frames_in_window(FRAME_RATE_HZ, TRIP_WINDOW_US));

  logic [N_HB-1:0] drive_mod, latched, trip_evt;

  for (genvar i = 0; i < N_HB; i++) begin : g_hb
    hb_limiter #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_lim (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_start(frame_start),
      .pwm        (pwm_in[i]),
      .oc         (oc_in[i]),
      .latch_mode (latch_mode),
      .drive_mod  (drive_mod[i]),
      .latched    (latched[i]),
      .trip_evt   (trip_evt[i])
    );
  end

  hb_pairing #(.N_HB(N_HB)) u_pair (
    .latched(latched),
    .se_mode(se_mode),
    .hiz    (hiz_out)
  );

  assign drive_out = drive_mod & ~hiz_out;
  assign fault_out = latched;

endmodule

// File: rtl/hb_oc_guard_chk.sv
module hb_oc_guard_chk #(
  parameter int N_HB = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_start,
  input logic [N_HB-1:0] pwm_in,
  input logic [N_HB-1:0] oc_in,
  input logic            latch_mode,
  input logic            se_mode,
  input logic [N_HB-1:0] drive_out,
  input logic [N_HB-1:0] hiz_out,
  input logic [N_HB-1:0] fault_out,
  input logic [N_HB-1:0] trip_evt
);
  for (genvar i = 0; i < N_HB; i++) begin : g_chk
    localparam int P = i ^ 1;

    p_hiz_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      hiz_out[i] |-> !drive_out[i]);

    p_fault_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fault_out[i] |=> fault_out[i]);

    p_latch_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_mode && oc_in[i] && !fault_out[i]) |=> fault_out[i]);

    p_trip_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      trip_evt[i] |=> fault_out[i]);

    p_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_mode && oc_in[i] && !fault_out[i] && !frame_start)
        |=> (hiz_out[i] || (drive_out[i] != pwm_in[i])));

    p_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!se_mode && fault_out[i]) |-> hiz_out[P]);

    p_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (se_mode && !fault_out[i]) |-> !hiz_out[i]);
  end
endmodule

bind hb_oc_guard hb_oc_guard_chk #(.N_HB(N_HB)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_start(frame_start),
  .pwm_in     (pwm_in),
  .oc_in      (oc_in),
  .latch_mode (latch_mode),
  .se_mode    (se_mode),
  .drive_out  (drive_out),
  .hiz_out    (hiz_out),
  .fault_out  (fault_out),
  .trip_evt   (trip_evt)
);

// File: tb/hb_oc_guard_bench.sv
module hb_oc_guard_bench;
  localparam int CLK_P       = 10;
  localparam int TRIP_FRAMES = 1040;  // 400 kHz x 2.6 ms

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic [3:0] pwm_in = 4'b0;
  logic [3:0] oc_in = 4'b0;
  logic       latch_mode = 1'b0;
  logic       se_mode = 1'b0;
  logic [3:0] drive_out, hiz_out, fault_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  hb_oc_guard u_hb_oc_guard (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pwm_in(pwm_in),
    .oc_in(oc_in), .latch_mode(latch_mode), .se_mode(se_mode),
    .drive_out(drive_out), .hiz_out(hiz_out), .fault_out(fault_out)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Inputs change just after a falling edge; outputs are read at the next one.
  task automatic step(input logic fs, input logic [3:0] oc);
    frame_start = fs;
    oc_in = oc;
    @(negedge clk);
  endtask

  task automatic frame(input logic [3:0] oc_first, input logic [3:0] oc_mid);
    step(1'b1, oc_first);
    step(1'b0, oc_mid);
    step(1'b0, 4'b0);
    step(1'b0, 4'b0);
  endtask

  task automatic do_reset(input logic lm, input logic se);
    rst_n = 1'b0;
    frame_start = 1'b0;
    oc_in = 4'b0;
    latch_mode = lm;
    se_mode = se;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(1'b0, 1'b0);
    pwm_in = 4'b1010;
    step(1'b0, 4'b0);
    check("R1 hiz", hiz_out, 4'b0000);
    check("R1 fault", fault_out, 4'b0000);
    check("R1 drive", drive_out, 4'b1010);
    pwm_in = 4'b0101;
    step(1'b0, 4'b0);
    check("R1 drive2", drive_out, 4'b0101);
  endtask

  task automatic t_flip;
    do_reset(1'b0, 1'b0);
    pwm_in = 4'b1111;
    step(1'b1, 4'b0);
    step(1'b0, 4'b0001);
    check("R2 flip c1", drive_out, 4'b1110);
    step(1'b0, 4'b0);
    check("R2 flip c2", drive_out, 4'b1110);
    pwm_in = 4'b0000;
    step(1'b0, 4'b0);
    check("R2 flip follows pwm", drive_out, 4'b0001);
    step(1'b1, 4'b0);
    check("R2 clear at frame", drive_out, 4'b0000);
    check("R2 no fault", fault_out, 4'b0000);
  endtask

  task automatic t_leak;
    do_reset(1'b0, 1'b0);
    pwm_in = 4'b0110;
    for (int k = 0; k < 1100; k++) begin
      frame(4'b0, 4'b0010);
      frame(4'b0, 4'b0);
    end
    check("R3 leak keeps healthy", fault_out, 4'b0000);
  endtask

  task automatic t_trip;
    do_reset(1'b0, 1'b0);
    pwm_in = 4'b1111;
    for (int k = 0; k < 5; k++) frame(4'b0, 4'b0);
    for (int k = 0; k < TRIP_FRAMES - 1; k++) frame(4'b0, 4'b0100);
    check("R10 not yet tripped", fault_out, 4'b0000);
    step(1'b1, 4'b0);
    step(1'b0, 4'b0100);
    check("R4 trip fault", fault_out, 4'b0100);
    check("R7 pair hiz", hiz_out, 4'b1100);
    check("R11 drive low", drive_out, 4'b0011);
  endtask

  task automatic t_conc;
    do_reset(1'b0, 1'b0);
    pwm_in = 4'b0000;
    for (int k = 0; k < TRIP_FRAMES - 1; k++) frame(4'b0, 4'b0001);
    frame(4'b0, 4'b0);
    frame(4'b0001, 4'b0);
    check("R9 net zero", fault_out, 4'b0000);
    step(1'b1, 4'b0);
    step(1'b0, 4'b0001);
    check("R9 trips next event", fault_out, 4'b0001);
  endtask

  task automatic t_latch_se;
    do_reset(1'b1, 1'b1);
    pwm_in = 4'b1111;
    step(1'b1, 4'b0);
    step(1'b0, 4'b0010);
    check("R5 first event", fault_out, 4'b0010);
    check("R8 own hiz", hiz_out, 4'b0010);
    check("R11 drive", drive_out, 4'b1101);
    for (int k = 0; k < 10; k++) frame(4'b0, 4'b0);
    check("R6 held", fault_out, 4'b0010);
    do_reset(1'b1, 1'b1);
    check("R6 reset clears", fault_out, 4'b0000);
  endtask

  task automatic t_latch_btl;
    do_reset(1'b1, 1'b0);
    pwm_in = 4'b1111;
    step(1'b1, 4'b0);
    step(1'b0, 4'b1000);
    check("R5 bridge fault", fault_out, 4'b1000);
    check("R7 upper pair hiz", hiz_out, 4'b1100);
    check("R7 lower pair drive", drive_out, 4'b0011);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_flip();
    t_leak();
    t_trip();
    t_conc();
    t_latch_se();
    t_latch_btl();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule